// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital side of an auto-zeroing, auto-polarity dual-slope analog-to-digital converter. It runs free from reset, repeating a conversion of exactly `CYCLE_LEN` clocks (16,000 by default). Each conversion has six phases:

- Auto-zero: the integrator is shorted while the offset capacitor charges.
- Offset measurement: the block counts until the comparator first reads high and stores that count.
- Input integration: the unknown input is integrated for a fixed time.
- Reference deintegration: a reference of opposite sign is applied and the block counts until the comparator changes state.
- Two settle phases that pad the conversion to its fixed length.

The deintegration count, minus the stored offset count, is the reading. A reading equal to full scale is 1999.

The block drives four analog switch controls and a reference-sign select. It takes only the comparator output as feedback. At the end of each conversion it publishes the magnitude, a sign flag and two range flags, and pulses an end-of-conversion strobe. The published values then stay unchanged for the whole of the following conversion.

Top module: `dsadc_seq`

## Requirements
- R1: While reset is held (active low), `sw_short_o` and `sw_cap_o` are 1, `sw_inp_o` and `sw_ref_o` are 0, and `value_o`, `neg_o`, `over_o`, `under_o` and `eoc_o` are 0.
- R2: Each conversion starts with an auto-zero phase of exactly 4000 clocks. During this phase `sw_short_o` and `sw_cap_o` are both 1, and outside it both are 0.
- R3: The offset phase follows auto-zero and drives no switch. In offset-phase clock k (k counted from 0), if `comp_i` is 1, the offset count becomes k and the phase ends after that clock, so the phase lasts k+1 clocks.
- R4: If `comp_i` stays 0 for 800 offset-phase clocks, the offset phase ends after clock 799 and the offset count is 800.
- R5: The input phase holds `sw_inp_o` at 1 for exactly 2000 clocks. The value of `comp_i` in its last clock sets the sign: 1 means a positive input (`neg_o` = 0), and 0 means a negative input (`neg_o` = 1).
- R6: The deintegration phase holds `sw_ref_o` at 1, with `ref_neg_o` equal to 1 for a positive input and 0 for a negative one. In deintegration clock k, if `comp_i` differs from its value at the end of the input phase, the raw count becomes k and the phase ends after that clock. If no change has occurred after 4000 clocks, the raw count is 4000.
- R7: The reading is the raw count minus the offset count. When the reading lies between 0 and 1999, `value_o` shows it.
- R8: A reading above 1999 sets `over_o`, and `value_o` shows 1999.
- R9: A reading below 180 sets `under_o`. A negative reading shows as `value_o` = 0.
- R10: `eoc_o` is a one-clock pulse, first seen 16000 clocks after reset release and then every 16000 clocks. `value_o`, `neg_o`, `over_o` and `under_o` change only in the clock where `eoc_o` is 1.
- R11: At most one of `sw_short_o`, `sw_inp_o` and `sw_ref_o` is 1 in any clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| comp_i | input | 1 | Comparator output, 1 when the integrator is above threshold |
| sw_short_o | output | 1 | Integrator short switch |
| sw_cap_o | output | 1 | Offset capacitor charge switch |
| sw_inp_o | output | 1 | Unknown-input integrate switch |
| sw_ref_o | output | 1 | Reference deintegrate switch |
| ref_neg_o | output | 1 | Reference sign select during deintegration, 1 selects the negative reference |
| value_o | output | 11 | Magnitude of the last reading, 0 to 1999 |
| neg_o | output | 1 | Last input was negative |
| over_o | output | 1 | Last reading was above full scale |
| under_o | output | 1 | Last reading was below 180 |
| eoc_o | output | 1 | End-of-conversion pulse |

## Verification
The bench aims at the range edges: 1999 against 2000, 179 against 180, and a raw count below the offset count. A design with an off-by-one in its limit compare, or one that wraps the subtraction, shows the wrong flag or a value near 2047.

It also hits the two timeout paths:
- An offset comparator that never trips. A missing clamp gives an offset phase longer than 800 clocks.
- A deintegration that never ends. A missing clamp breaks the fixed 16,000-clock period.

A comparator that trips in the first offset clock, or in the last permitted one, exposes a count that is taken one clock early or late. Tracking both polarities catches a reference sign that is not inverted.

// File: rtl/dsadc_seq_pkg.sv
package dsadc_seq_pkg;

   typedef enum logic [2:0] {
      PH_ZERO   = 3'd0,
      PH_OFFS   = 3'd1,
      PH_INTEG  = 3'd2,
      PH_DEINT  = 3'd3,
      PH_SETTLE = 3'd4,
      PH_PAD    = 3'd5
   } phase_e;

   localparam int NUM_PH = 6;

   typedef struct packed {
      logic shrt;
      logic cap;
      logic inp;
      logic refs;
   } sw_t;

endpackage

// File: rtl/dsadc_phase_ctrl.sv
module dsadc_phase_ctrl
   import dsadc_seq_pkg::*;
#(
   parameter int AZ_LEN     = 4000,
   parameter int OFS_MAX    = 800,
   parameter int INT_LEN    = 2000,
   parameter int DEINT_MAX  = 4000,
   parameter int SETTLE_LEN = 200,
   parameter int CYCLE_LEN  = 16000,
   parameter int CNT_W      = 13,
   parameter int CYC_W      = 14
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             comp_i,
   output phase_e           phase_o,
   output logic [CNT_W-1:0] ofs_cnt_o,
   output logic [CNT_W-1:0] raw_cnt_o,
   output logic             pos_o,
   output logic             wrap_o
);

   localparam logic [CNT_W-1:0] AZ_END     = CNT_W'(AZ_LEN - 1);
   localparam logic [CNT_W-1:0] OFS_END    = CNT_W'(OFS_MAX - 1);
   localparam logic [CNT_W-1:0] OFS_CLAMP  = CNT_W'(OFS_MAX);
   localparam logic [CNT_W-1:0] INT_END    = CNT_W'(INT_LEN - 1);
   localparam logic [CNT_W-1:0] DEINT_END  = CNT_W'(DEINT_MAX - 1);
   localparam logic [CNT_W-1:0] DEINT_CLMP = CNT_W'(DEINT_MAX);
   localparam logic [CNT_W-1:0] SET_END    = CNT_W'(SETTLE_LEN - 1);
   localparam logic [CYC_W-1:0] CYC_END    = CYC_W'(CYCLE_LEN - 1);

   phase_e           phase_q;
   logic [CNT_W-1:0] seg_cnt_q;
   logic [CYC_W-1:0] cyc_q;
   logic [CNT_W-1:0] ofs_q;
   logic [CNT_W-1:0] raw_q;
   logic             pos_q;
   logic             last_cyc;

   assign last_cyc = (cyc_q == CYC_END);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cyc_q <= '0;
      end else if (last_cyc) begin
         cyc_q <= '0;
      end else begin
         cyc_q <= cyc_q + 1'b1;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         phase_q   <= PH_ZERO;
         seg_cnt_q <= '0;
         ofs_q     <= '0;
         raw_q     <= '0;
         pos_q     <= 1'b0;
      end else begin
         unique case (phase_q)
            PH_ZERO: begin
               if (seg_cnt_q == AZ_END) begin
                  phase_q   <= PH_OFFS;
                  seg_cnt_q <= '0;
               end else begin
                  seg_cnt_q <= seg_cnt_q + 1'b1;
               end
            end
            PH_OFFS: begin
               if (comp_i) begin
                  ofs_q     <= seg_cnt_q;
                  phase_q   <= PH_INTEG;
                  seg_cnt_q <= '0;
               end else if (seg_cnt_q == OFS_END) begin
                  ofs_q     <= OFS_CLAMP;
                  phase_q   <= PH_INTEG;
                  seg_cnt_q <= '0;
               end else begin
                  seg_cnt_q <= seg_cnt_q + 1'b1;
               end
            end
            PH_INTEG: begin
               if (seg_cnt_q == INT_END) begin
                  pos_q     <= comp_i;
                  phase_q   <= PH_DEINT;
                  seg_cnt_q <= '0;
               end else begin
                  seg_cnt_q <= seg_cnt_q + 1'b1;
               end
            end
            PH_DEINT: begin
               if (comp_i != pos_q) begin
                  raw_q     <= seg_cnt_q;
                  phase_q   <= PH_SETTLE;
                  seg_cnt_q <= '0;
               end else if (seg_cnt_q == DEINT_END) begin
                  raw_q     <= DEINT_CLMP;
                  phase_q   <= PH_SETTLE;
                  seg_cnt_q <= '0;
               end else begin
                  seg_cnt_q <= seg_cnt_q + 1'b1;
               end
            end
            PH_SETTLE: begin
               if (seg_cnt_q == SET_END) begin
                  phase_q   <= PH_PAD;
                  seg_cnt_q <= '0;
               end else begin
                  seg_cnt_q <= seg_cnt_q + 1'b1;
               end
            end
            PH_PAD: begin
               if (last_cyc) begin
                  phase_q   <= PH_ZERO;
                  seg_cnt_q <= '0;
               end
            end
            default: begin
               phase_q   <= PH_ZERO;
               seg_cnt_q <= '0;
            end
         endcase
      end
   end

   assign phase_o   = phase_q;
   assign ofs_cnt_o = ofs_q;
   assign raw_cnt_o = raw_q;
   assign pos_o     = pos_q;
   assign wrap_o    = last_cyc;

   // R4
   ofs_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ofs_q <= OFS_CLAMP);

   // R3
   ofs_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (phase_q == PH_OFFS && comp_i) |=> (phase_q == PH_INTEG && ofs_q == $past(seg_cnt_q)));

   // R6
   raw_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      raw_q <= DEINT_CLMP);

   // R2
   wrap_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wrap_o |=> (phase_q == PH_ZERO && seg_cnt_q == '0 && cyc_q == '0));

   // R10
   wrap_in_pad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wrap_o |-> phase_q == PH_PAD);

endmodule

// File: rtl/dsadc_sw_decode.sv
module dsadc_sw_decode
   import dsadc_seq_pkg::*;
#(
   parameter int PH_CNT = NUM_PH
) (
   input  phase_e phase_i,
   input  logic   pos_i,
   output sw_t    sw_o,
   output logic   ref_neg_o
);

   function automatic sw_t ph_mask(input int p);
      sw_t m;
      m = '0;
      case (p)
         0:       begin m.shrt = 1'b1; m.cap = 1'b1; end
         2:       m.inp  = 1'b1;
         3:       m.refs = 1'b1;
         default: m = '0;
      endcase
      return m;
   endfunction

   sw_t masked [PH_CNT];

   for (genvar g = 0; g < PH_CNT; g++) begin : g_ph
      assign masked[g] = (phase_i == phase_e'(g)) ? ph_mask(g) : sw_t'('0);
   end

   always_comb begin
      sw_o = '0;
      for (int p = 0; p < PH_CNT; p++) begin
         sw_o = sw_t'(sw_o | masked[p]);
      end
   end

   assign ref_neg_o = sw_o.refs & pos_i;

endmodule

// File: rtl/dsadc_result_calc.sv
module dsadc_result_calc #(
   parameter int CNT_W     = 13,
   parameter int VAL_W     = 11,
   parameter int FULL      = 1999,
   parameter int UNDER_LIM = 180
) (
   input  logic [CNT_W-1:0] raw_i,
   input  logic [CNT_W-1:0] ofs_i,
   output logic [VAL_W-1:0] value_o,
   output logic             over_o,
   output logic             under_o
);

   localparam logic signed [CNT_W:0] FULL_S  = (CNT_W+1)'(FULL);
   localparam logic signed [CNT_W:0] UNDER_S = (CNT_W+1)'(UNDER_LIM);

   logic signed [CNT_W:0] diff;

   assign diff    = $signed({1'b0, raw_i}) - $signed({1'b0, ofs_i});
   assign over_o  = diff > FULL_S;
   assign under_o = diff < UNDER_S;

   always_comb begin
      if (over_o) begin
         value_o = VAL_W'(FULL);
      end else if (diff < 0) begin
         value_o = '0;
      end else begin
         value_o = diff[VAL_W-1:0];
      end
   end

endmodule

// File: rtl/dsadc_seq.sv
module dsadc_seq
   import dsadc_seq_pkg::*;
#(
   parameter int AZ_LEN     = 4000,
   parameter int OFS_MAX    = 800,
   parameter int INT_LEN    = 2000,
   parameter int DEINT_MAX  = 4000,
   parameter int SETTLE_LEN = 200,
   parameter int CYCLE_LEN  = 16000,
   parameter int FULL       = 1999,
   parameter int UNDER_LIM  = 180
) (
   input  logic        clk_i,
   input  logic        rst_ni,
   input  logic        comp_i,
   output logic        sw_short_o,
   output logic        sw_cap_o,
   output logic        sw_inp_o,
   output logic        sw_ref_o,
   output logic        ref_neg_o,
   output logic [10:0] value_o,
   output logic        neg_o,
   output logic        over_o,
   output logic        under_o,
   output logic        eoc_o
);

   localparam int MAX_A   = (AZ_LEN > DEINT_MAX) ? AZ_LEN : DEINT_MAX;
   localparam int MAX_B   = (INT_LEN > SETTLE_LEN) ? INT_LEN : SETTLE_LEN;
   localparam int MAX_C   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int CNT_MAX = (MAX_C > OFS_MAX) ? MAX_C : OFS_MAX;
   localparam int CNT_W   = $clog2(CNT_MAX + 1);
   localparam int CYC_W   = $clog2(CYCLE_LEN);
   localparam int VAL_W   = $clog2(FULL + 1);
   localparam int BUSY    = AZ_LEN + OFS_MAX + INT_LEN + DEINT_MAX + SETTLE_LEN;

   if (BUSY >= CYCLE_LEN) begin : g_len_bad
      $error("phase lengths exceed conversion length");
   end
   if (VAL_W != 11) begin : g_val_bad
      $error("full scale must fit the 11-bit value port");
   end
   if (UNDER_LIM > FULL || FULL >= DEINT_MAX) begin : g_lim_bad
      $error("range limits inconsistent");
   end
   if (AZ_LEN < 1 || OFS_MAX < 1 || INT_LEN < 1 || SETTLE_LEN < 1) begin : g_min_bad
      $error("phase lengths must be nonzero");
   end

   phase_e           phase;
   logic [CNT_W-1:0] ofs_cnt;
   logic [CNT_W-1:0] raw_cnt;
   logic             pos;
   logic             wrap;
   sw_t              sw;
   logic [VAL_W-1:0] calc_val;
   logic             calc_over;
   logic             calc_under;

   dsadc_phase_ctrl #(
      .AZ_LEN     (AZ_LEN),
      .OFS_MAX    (OFS_MAX),
      .INT_LEN    (INT_LEN),
      .DEINT_MAX  (DEINT_MAX),
      .SETTLE_LEN (SETTLE_LEN),
      .CYCLE_LEN  (CYCLE_LEN),
      .CNT_W      (CNT_W),
      .CYC_W      (CYC_W)
   ) u_ctrl (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .comp_i    (comp_i),
      .phase_o   (phase),
      .ofs_cnt_o (ofs_cnt),
      .raw_cnt_o (raw_cnt),
      .pos_o     (pos),
      .wrap_o    (wrap)
   );

   dsadc_sw_decode #(
      .PH_CNT (NUM_PH)
   ) u_sw (
      .phase_i   (phase),
      .pos_i     (pos),
      .sw_o      (sw),
      .ref_neg_o (ref_neg_o)
   );

   dsadc_result_calc #(
      .CNT_W     (CNT_W),
      .VAL_W     (VAL_W),
      .FULL      (FULL),
      .UNDER_LIM (UNDER_LIM)
   ) u_calc (
      .raw_i   (raw_cnt),
      .ofs_i   (ofs_cnt),
      .value_o (calc_val),
      .over_o  (calc_over),
      .under_o (calc_under)
   );

   assign sw_short_o = sw.shrt;
   assign sw_cap_o   = sw.cap;
   assign sw_inp_o   = sw.inp;
   assign sw_ref_o   = sw.refs;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         eoc_o   <= 1'b0;
         value_o <= '0;
         neg_o   <= 1'b0;
         over_o  <= 1'b0;
         under_o <= 1'b0;
      end else begin
         eoc_o <= wrap;
         if (wrap) begin
            value_o <= calc_val;
            neg_o   <= ~pos;
            over_o  <= calc_over;
            under_o <= calc_under;
         end
      end
   end

   // R10
   eoc_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      eoc_o |=> !eoc_o);

   // R10
   result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !eoc_o |-> ($stable(value_o) && $stable(neg_o) && $stable(over_o) && $stable(under_o)));

   // R8
   over_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      over_o |-> value_o == 11'(FULL));

   // R9
   under_lim_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      under_o |-> (value_o < 11'(UNDER_LIM) && !over_o));

   // R11
   sw_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({sw_short_o, sw_inp_o, sw_ref_o}));

   // R6
   ref_sign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ref_neg_o |-> sw_ref_o);

endmodule

// File: tb/dsadc_seq_tb_top.sv
module dsadc_seq_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        comp = 1'b0;
   logic        sw_short, sw_cap, sw_inp, sw_ref, ref_neg;
   logic [10:0] value;
   logic        neg, over, under, eoc;

   always #4 clk = ~clk;

   dsadc_seq dut_i (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .comp_i     (comp),
      .sw_short_o (sw_short),
      .sw_cap_o   (sw_cap),
      .sw_inp_o   (sw_inp),
      .sw_ref_o   (sw_ref),
      .ref_neg_o  (ref_neg),
      .value_o    (value),
      .neg_o      (neg),
      .over_o     (over),
      .under_o    (under),
      .eoc_o      (eoc)
   );

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   int j_s = 0, d_s = 0;
   bit p_s = 1'b0;

   int l1 = 0, l2 = 0, l3 = 0, l4 = 0, last_ph = 0;
   int s1, s2, s3, s4, s_per;
   int cyc_n = 0, last_eoc = 0;
   bit prev_eoc = 1'b0;
   bit err_ref = 1'b0, err_excl = 1'b0, err_cap = 1'b0, err_hold = 1'b0, err_eoc = 1'b0;
   logic [10:0] pub_val = '0;

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int exp_diff(input int j, input int d);
      int je = (j >= 800) ? 800 : j;
      int de = (d >= 4000) ? 4000 : d;
      return de - je;
   endfunction

   function automatic int exp_val(input int diff);
      if (diff > 1999) return 1999;
      if (diff < 0) return 0;
      return diff;
   endfunction

   // comparator model and phase monitor
   initial begin
      forever begin
         int ph;
         @(negedge clk);
         if (rst_n) begin
            if (eoc) begin
               s1 = l1; s2 = l2; s3 = l3; s4 = l4;
               s_per = cyc_n - last_eoc;
               last_eoc = cyc_n;
               l1 = 0; l2 = 0; l3 = 0; l4 = 0;
               pub_val = value;
               if (prev_eoc) err_eoc = 1'b1;
            end else if (value != pub_val) begin
               err_hold = 1'b1;
            end
            prev_eoc = eoc;
            cyc_n++;
            if (sw_short) ph = 1;
            else if (sw_inp) ph = 3;
            else if (sw_ref) ph = 4;
            else if (last_ph == 1 || last_ph == 2) ph = 2;
            else ph = 5;
            last_ph = ph;
            if (int'(sw_short) + int'(sw_inp) + int'(sw_ref) > 1) err_excl = 1'b1;
            if (sw_cap != sw_short) err_cap = 1'b1;
            case (ph)
               1: begin comp = 1'b0; l1++; end
               2: begin comp = (l2 >= j_s); l2++; end
               3: begin comp = p_s; l3++; end
               4: begin
                  comp = (l4 >= d_s) ? !p_s : p_s;
                  if (ref_neg != p_s) err_ref = 1'b1;
                  l4++;
               end
               default: comp = 1'b0;
            endcase
         end
      end
   end

   task automatic get_stim(input int n, output int j, output int d, output bit p);
      case (n)
         0: begin j = 30;  d = 2029; p = 1'b1; end
         1: begin j = 30;  d = 2030; p = 1'b1; end
         2: begin j = 0;   d = 180;  p = 1'b0; end
         3: begin j = 100; d = 279;  p = 1'b1; end
         4: begin j = 900; d = 1000; p = 1'b0; end
         5: begin j = 5;   d = 9999; p = 1'b1; end
         6: begin j = 500; d = 100;  p = 1'b0; end
         7: begin j = 799; d = 1500; p = 1'b1; end
         default: begin
            j = int'($urandom_range(850, 0));
            d = int'($urandom_range(4100, 0));
            p = 1'($urandom_range(1, 0));
         end
      endcase
   endtask

   initial begin
      int nj, nd;
      bit np;
      void'($urandom(32'd4242));
      get_stim(0, nj, nd, np);
      j_s = nj; d_s = nd; p_s = np;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      chk("R1 short", int'(sw_short), 1);
      chk("R1 cap", int'(sw_cap), 1);
      chk("R1 inp/ref", int'(sw_inp) + int'(sw_ref), 0);
      chk("R1 value", int'(value), 0);
      chk("R1 flags", int'(neg) + int'(over) + int'(under) + int'(eoc), 0);
      @(posedge clk);
      #1 rst_n = 1'b1;
      for (int n = 0; n < 10; n++) begin
         int cj, cd, df;
         bit cp;
         cj = j_s; cd = d_s; cp = p_s;
         do @(negedge clk); while (eoc !== 1'b1);
         #1;
         df = exp_diff(cj, cd);
         chk("R10 period", s_per, 16000);
         chk("R2 zero len", s1, 4000);
         chk("R3/R4 offset len", s2, (cj < 800) ? cj + 1 : 800);
         chk("R5 integ len", s3, 2000);
         chk("R6 deint len", s4, (cd < 4000) ? cd + 1 : 4000);
         chk("R7 value", int'(value), exp_val(df));
         chk("R5 neg", int'(neg), cp ? 0 : 1);
         chk("R8 over", int'(over), (df > 1999) ? 1 : 0);
         chk("R9 under", int'(under), (df < 180) ? 1 : 0);
         chk("R6 ref sign", int'(err_ref), 0);
         chk("R11 exclusive", int'(err_excl), 0);
         chk("R2 cap follows short", int'(err_cap), 0);
         chk("R10 hold/width", int'(err_hold) + int'(err_eoc), 0);
         get_stim(n + 1, nj, nd, np);
         j_s = nj; d_s = nd; p_s = np;
      end
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule